// File: doc/BRIEF.md
# Two-Stage Bus Clock Prescaler

This block turns the peripheral clock into the bit timing for a two-wire serial bus master. Two counters in series set the speed. The first divides the clock by one more than a 2-bit divisor. The second divides those pulses by one more than a 6-bit divisor. Each pulse that comes out of the second counter is one prescaled tick. A bus bit always lasts 22 ticks: 11 ticks with the clock line low, then 11 ticks with it high. The serial clock rate is therefore the input clock divided by 22·(a+1)·(b+1). The fastest possible rate is the input clock divided by 22.

The bit engine sees two level outputs, one for the low phase and one for the high phase. It also sees a one-cycle strobe that carries a 2-bit index marking four points within the bit. The bit engine drives `busy` for the whole transfer and pulses `start` to begin it, or to realign it for a repeated start. The divisor fields are read from the control word only at a start or while `busy` is low. A change made to the control word in the middle of a transfer has no effect until the next start or idle period.

Top module: `scl_prescaler`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `scl_low_ph`, `scl_high_ph` and `qtr_stb` are all 0.
- R2: With `busy` low and `start` low, the outputs after the next edge show both phase outputs at 0 and no strobe. The outputs also stay at 0 while `busy` is high if no `start` has been seen since the last idle cycle.
- R3: On the output sample right after the edge that captures `start`, `scl_low_ph` is 1, `qtr_stb` is 1 and `qtr_sel` is 0.
- R4: The divisors are read from the control word: divisor a at bits 15:14 and divisor b at bits 13:8. One tick lasts P=(a+1)·(b+1) clocks. Counting k clocks from the start edge, the phase index is floor(k/P) mod 22. `scl_low_ph` is 1 for phase 0..10, and `scl_high_ph` is 1 for phase 11..21.
- R5: `qtr_stb` pulses for exactly one clock, on the first clock of phase 0, 5, 11 and 16. `qtr_sel` is 0, 1, 2 and 3 at those points, in that order.
- R6: The divisor fields are sampled only at a `start` or while `busy` is low. Writes to the control word during a transfer do not change the timing.
- R7: A `start` during a busy transfer resets the phase to 0. A full 11-tick low phase then follows, timed with the newly sampled divisors.
- R8: `scl_low_ph` and `scl_high_ph` are never 1 together, and `qtr_stb` is only 1 while one of them is 1.
- R9: With both divisors at 0, a bit lasts exactly 22 clocks: 11 clocks low and 11 clocks high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 16 | Control word; divisor a in bits 15:14, divisor b in bits 13:8 |
| busy | input | 1 | High while the bit engine runs a transfer |
| start | input | 1 | One-cycle request to begin a bit sequence or realign it |
| scl_low_ph | output | 1 | High during the 11-tick low phase |
| scl_high_ph | output | 1 | High during the 11-tick high phase |
| qtr_stb | output | 1 | One-cycle strobe at a marked point of the bit |
| qtr_sel | output | 2 | Index of the point reported by the strobe |

## Verification
Two situations are hard to reach from the ports. One is a divisor change during a running transfer. The other is a repeated start that lands somewhere in the middle of a bit. To reach the first, the stimulus scrambles the control word on every clock of selected transfers, while the expected model keeps the divisors that were latched at the start. To reach the second, random-length partial transfers are chained into one another without an idle cycle. This puts the realigning start at arbitrary phase and tick offsets, and each one is checked for a full-length low phase under the new divisors. The largest divisor setting is covered by one directed full bit, which exercises the counters at their widest values.

// File: rtl/scl_presc_pkg.sv
package scl_presc_pkg;

  localparam int BIT_TICKS = 22;

  // Tick offset of marker q (0..3) inside a bit of 'ticks' ticks.
  function automatic int qpoint(input int q, input int ticks);
    int half;
    half = ticks / 2;
    case (q)
      0:       return 0;
      1:       return half / 2;
      2:       return half;
      default: return half + half / 2;
    endcase
  endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = en & (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/bit_phaser.sv
module bit_phaser
  import scl_presc_pkg::*;
#(
  parameter int TICKS = BIT_TICKS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       align,
  input  logic       park,
  input  logic       adv,
  output logic       ph_low,
  output logic       ph_high,
  output logic       q_stb,
  output logic [1:0] q_sel
);
  localparam int PW   = $clog2(TICKS);
  localparam int HALF = TICKS / 2;

  logic [PW-1:0] ph, ph_n;
  logic [3:0]    hit;
  logic          stb_n;
  logic [1:0]    sel_n;

  always_comb begin
    ph_n = ph;
    if (align || park)
      ph_n = '0;
    else if (adv)
      ph_n = (ph == PW'(TICKS - 1)) ? '0 : ph + 1'b1;
  end

  for (genvar q = 0; q < 4; q++) begin : g_mark
    assign hit[q] = (ph_n == PW'(qpoint(q, TICKS)));
  end

  always_comb begin
    sel_n = 2'd0;
    for (int q = 0; q < 4; q++)
      if (hit[q]) sel_n = 2'(q);
    stb_n = align | (adv & ~park & (|hit));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      ph_low  <= 1'b0;
      ph_high <= 1'b0;
      q_stb   <= 1'b0;
      q_sel   <= 2'd0;
    end else begin
      ph      <= ph_n;
      ph_low  <= ~park & (ph_n <  PW'(HALF));
      ph_high <= ~park & (ph_n >= PW'(HALF));
      q_stb   <= stb_n;
      if (stb_n) q_sel <= sel_n;
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_presc_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int DIVA_LSB = 14,
  parameter int DIVA_W   = 2,
  parameter int DIVB_LSB = 8,
  parameter int DIVB_W   = 6,
  parameter int TICKS    = BIT_TICKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              busy,
  input  logic              start,
  output logic              scl_low_ph,
  output logic              scl_high_ph,
  output logic              qtr_stb,
  output logic [1:0]        qtr_sel
);
  logic [DIVA_W-1:0] sh_a;
  logic [DIVB_W-1:0] sh_b;
  logic running, go, clr, a_wrap, tick;

  // Divisor shadows: follow the control word only when idle or at a start.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_a <= '0;
      sh_b <= '0;
    end else if (start || !busy) begin
      sh_a <= ctrl_word[DIVA_LSB +: DIVA_W];
      sh_b <= ctrl_word[DIVB_LSB +: DIVB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= start | (running & busy);
  end

  assign go  = running & busy;
  assign clr = start | ~go;

  div_stage #(.W(DIVA_W)) u_stage_a (
    .clk(clk), .rst(rst), .clr(clr), .en(go), .limit(sh_a), .wrap(a_wrap)
  );

  div_stage #(.W(DIVB_W)) u_stage_b (
    .clk(clk), .rst(rst), .clr(clr), .en(a_wrap), .limit(sh_b), .wrap(tick)
  );

  bit_phaser #(.TICKS(TICKS)) u_phaser (
    .clk(clk), .rst(rst),
    .align(start), .park(~start & ~go), .adv(tick),
    .ph_low(scl_low_ph), .ph_high(scl_high_ph),
    .q_stb(qtr_stb), .q_sel(qtr_sel)
  );
endmodule

// File: rtl/scl_presc_chk.sv
module scl_presc_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       start,
  input logic       scl_low_ph,
  input logic       scl_high_ph,
  input logic       qtr_stb,
  input logic [1:0] qtr_sel
);
  a_r8_phase_excl: assert property (@(posedge clk) disable iff (rst)
    !(scl_low_ph && scl_high_ph));

  a_r8_stb_in_phase: assert property (@(posedge clk) disable iff (rst)
    qtr_stb |-> (scl_low_ph || scl_high_ph));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (!scl_low_ph && !scl_high_ph && !qtr_stb));

  a_r3_start_align: assert property (@(posedge clk) disable iff (rst)
    start |=> (scl_low_ph && qtr_stb && qtr_sel == 2'd0));

  a_r5_mid_marker: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_high_ph) |-> (qtr_stb && qtr_sel == 2'd2));

  a_r5_low_marker: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_low_ph) |-> (qtr_stb && qtr_sel == 2'd0));
endmodule

bind scl_prescaler scl_presc_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .start(start),
  .scl_low_ph(scl_low_ph), .scl_high_ph(scl_high_ph),
  .qtr_stb(qtr_stb), .qtr_sel(qtr_sel)
);

// File: tb/sim_scl_prescaler.sv
module sim_scl_prescaler;
  logic        clk = 1'b0;
  logic        rst, busy, start;
  logic [15:0] ctrl_word;
  logic        scl_low_ph, scl_high_ph, qtr_stb;
  logic [1:0]  qtr_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_prescaler u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .busy(busy), .start(start),
    .scl_low_ph(scl_low_ph), .scl_high_ph(scl_high_ph),
    .qtr_stb(qtr_stb), .qtr_sel(qtr_sel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_phase(input int k, input int p);
    return (k / p) % 22;
  endfunction

  function automatic int exp_marker(input int ph);
    case (ph)
      0: return 0; 5: return 1; 11: return 2; 16: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic step_check(input int k, input int p, input string req);
    int ph, mk; bit stb;
    ph  = exp_phase(k, p);
    mk  = exp_marker(ph);
    stb = (k % p == 0) && (mk >= 0);
    chk(scl_low_ph  == (ph < 11),  req, "low",  scl_low_ph,  int'(ph < 11));
    chk(scl_high_ph == (ph >= 11), req, "high", scl_high_ph, int'(ph >= 11));
    chk(qtr_stb == stb, req, "stb", qtr_stb, int'(stb));
    if (stb) chk(qtr_sel == 2'(mk), req, "sel", qtr_sel, mk);
  endtask

  // At a negedge: pulse start with divisors a,b, then check n samples.
  task automatic xfer(input int a, input int b, input int n,
                      input bit scramble, input string req);
    int p;
    p = (a + 1) * (b + 1);
    ctrl_word = 16'($urandom);
    ctrl_word[15:14] = 2'(a);
    ctrl_word[13:8]  = 6'(b);
    busy  = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      step_check(k, p, req);
      if (scramble) ctrl_word = 16'($urandom);  // R6: must be ignored
      @(negedge clk);
    end
  endtask

  task automatic go_idle(input int cyc);
    busy  = 1'b0;
    start = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      ctrl_word = 16'($urandom);
      @(negedge clk);
      chk(!scl_low_ph && !scl_high_ph && !qtr_stb, "R2", "idle outputs",
          {scl_low_ph, scl_high_ph, qtr_stb}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int a, b, p;
    seed = $urandom(32'd2024);
    rst = 1'b1; busy = 1'b0; start = 1'b0; ctrl_word = '0;
    repeat (3) @(negedge clk);
    chk(!scl_low_ph && !scl_high_ph && !qtr_stb, "R1", "reset outputs",
        {scl_low_ph, scl_high_ph, qtr_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_low_ph && !scl_high_ph && !qtr_stb, "R1", "post-reset outputs",
        {scl_low_ph, scl_high_ph, qtr_stb}, 0);

    // R2: busy without start stays quiet
    busy = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!scl_low_ph && !scl_high_ph, "R2", "busy without start",
          {scl_low_ph, scl_high_ph}, 0);
    end
    go_idle(2);

    // R9 / R3: fastest setting, three bits
    xfer(0, 0, 66, 1'b0, "R9");
    go_idle(3);

    // R4: widest divisors, one full bit plus wrap
    xfer(3, 63, 22 * 256 + 3, 1'b0, "R4");
    go_idle(2);

    // R7: repeated start in the middle of a bit
    xfer(1, 2, 50, 1'b0, "R7");
    xfer(2, 1, 6 * 22 + 7, 1'b0, "R7");
    go_idle(2);

    // Random transfers; odd ones scramble the control word (R6),
    // every third one chains into the next without idle (R7).
    for (int i = 0; i < 10; i++) begin
      a = int'($urandom % 4);
      b = int'($urandom % 8);
      p = (a + 1) * (b + 1);
      if (i % 3 == 0) begin
        xfer(a, b, 1 + int'($urandom % (22 * p)), i % 2 == 1, "R7");
      end else begin
        xfer(a, b, 44 * p + 3, i % 2 == 1, (i % 2 == 1) ? "R6" : "R5");
        go_idle(1 + int'($urandom % 3));
      end
    end
    go_idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule